// File: doc/BRIEF.md
# Word-Wide CRC-32 Accelerator

This block is a small register-mapped checksum engine for integrity checks of memory images. Software writes 32-bit words, one per bus write, into the data register. Each word folds into a running 32-bit remainder in a single clock cycle. Reading the data register returns the current remainder.

The engine uses the generator polynomial 0x04C11DB7 and shifts to the left, most significant bit first. Neither input nor output is bit-reflected, and no final XOR is applied. A word assembled little-endian from memory bytes therefore enters with its bit 31 first. Because there is no final XOR, writing the remainder itself as the next word leaves a zero residue. A checker can run an image plus its appended checksum through the engine and compare the result with zero.

A control register restarts the calculation from a programmable seed. An 8-bit scratch register is also provided. A clock-enable input gates the whole unit.

Top module: `crc_word_unit`

## Requirements
- R1: After reset, the data register (word offset 0) reads 0xFFFFFFFF, the seed register (offset 4) reads 0xFFFFFFFF, the scratch register (offset 1) reads 0 and the control register (offset 2) reads 0.
- R2: A write to offset 0 with clkEn high updates the remainder in one cycle. The update is 32 left shifts with polynomial 0x04C11DB7, driven by data bit 31 down to bit 0. The new value reads back on the next cycle.
- R3: From the reset state, feeding 0x0000000A gives 0xE88E0BAD. This is the little-endian word of bytes 0a 00 00 00.
- R4: Writing the current remainder as the next data word leaves 0x00000000. In particular, 0xFFFFFFFF fed from reset gives 0.
- R5: Writing a value with bit 0 set to offset 2 loads the remainder from the seed register on the next cycle. With the default seed, offset 0 then reads 0xFFFFFFFF.
- R6: The control register always reads 0. A write to it with bit 0 clear leaves the remainder unchanged.
- R7: The seed register (offset 4) is readable and writable over all 32 bits. A restart loads its current contents, and writing it does not change the remainder.
- R8: The scratch register keeps bits 7:0 of a write and reads 0 in bits 31:8. It survives a restart and has no effect on the remainder.
- R9: While clkEn is low, every write is ignored and every read returns 0.
- R10: Offsets 3, 5, 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Unit enable; when low the unit ignores writes and reads return 0 |
| wrEn | input | 1 | Write strobe for the register at addr |
| addr | input | 3 | Word offset of the accessed register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for addr |

## Verification
A wrong bit in the remainder register does not fade away. It reaches the data-register read on the very next cycle and stays in every later remainder until a restart, so one read after each feed is enough to expose it. A wrong seed or scratch value appears only when that register is read back, or, for the seed, one cycle after a restart. Reads of the ignored offsets and reads with clkEn low show misdecoding at once.

// File: rtl/crc_unit_pkg.sv
package crc_unit_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int SCRATCH_W = 8;
  localparam logic [DATA_W-1:0] POLY = 32'h04C11DB7;
  localparam logic [DATA_W-1:0] SEED_RESET = '1;

  localparam logic [ADDR_W-1:0] OFF_DATA    = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_SCRATCH = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_SEED    = 3'd4;

  typedef enum logic [2:0] {
    SEL_DATA,
    SEL_SCRATCH,
    SEL_CTRL,
    SEL_SEED,
    SEL_NONE
  } regSel_t;

  typedef struct packed {
    logic feed;
    logic restart;
    logic loadSeed;
    logic loadScratch;
  } strobes_t;
endpackage

// File: rtl/crc_unit_ctrl.sv
module crc_unit_ctrl
  import crc_unit_pkg::*;
(
  input  logic              clkEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              restartBit,
  output strobes_t          strobes,
  output regSel_t           rdSel
);
  regSel_t decSel;

  always_comb begin
    unique case (addr)
      OFF_DATA:    decSel = SEL_DATA;
      OFF_SCRATCH: decSel = SEL_SCRATCH;
      OFF_CTRL:    decSel = SEL_CTRL;
      OFF_SEED:    decSel = SEL_SEED;
      default:     decSel = SEL_NONE;
    endcase
  end

  // Reads are blanked while the unit is disabled.
  assign rdSel = clkEn ? decSel : SEL_NONE;

  logic wrGo;
  assign wrGo = clkEn && wrEn;

  always_comb begin
    strobes = '0;
    strobes.feed        = wrGo && (decSel == SEL_DATA);
    strobes.loadScratch = wrGo && (decSel == SEL_SCRATCH);
    strobes.restart     = wrGo && (decSel == SEL_CTRL) && restartBit;
    strobes.loadSeed    = wrGo && (decSel == SEL_SEED);
  end
endmodule

// File: rtl/crc_unit_dp.sv
module crc_unit_dp
  import crc_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  regSel_t           rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] crcVal,
  output logic [DATA_W-1:0] seedVal,
  output logic [SCRATCH_W-1:0] scratchVal
);
  // Unrolled MSB-first division chain: stage k holds the remainder after
  // data bits DATA_W-1 .. DATA_W-k have entered.
  logic [DATA_W-1:0] stage [0:DATA_W];
  assign stage[0] = crcVal;

  for (genvar k = 0; k < DATA_W; k++) begin : g_step
    logic fb;
    assign fb = stage[k][DATA_W-1] ^ wrData[DATA_W-1-k];
    assign stage[k+1] = {stage[k][DATA_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcVal <= SEED_RESET;
    end else if (strobes.restart) begin
      crcVal <= seedVal;
    end else if (strobes.feed) begin
      crcVal <= stage[DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seedVal <= SEED_RESET;
    end else if (strobes.loadSeed) begin
      seedVal <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scratchVal <= '0;
    end else if (strobes.loadScratch) begin
      scratchVal <= wrData[SCRATCH_W-1:0];
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_DATA:    rdData = crcVal;
      SEL_SCRATCH: rdData = {{(DATA_W-SCRATCH_W){1'b0}}, scratchVal};
      SEL_SEED:    rdData = seedVal;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/crc_word_unit.sv
module crc_word_unit
  import crc_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  strobes_t strobes;
  regSel_t  rdSel;
  logic [DATA_W-1:0]    crcVal;
  logic [DATA_W-1:0]    seedVal;
  logic [SCRATCH_W-1:0] scratchVal;

  crc_unit_ctrl u_ctrl (
    .clkEn      (clkEn),
    .wrEn       (wrEn),
    .addr       (addr),
    .restartBit (wrData[0]),
    .strobes    (strobes),
    .rdSel      (rdSel)
  );

  crc_unit_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rdSel      (rdSel),
    .wrData     (wrData),
    .rdData     (rdData),
    .crcVal     (crcVal),
    .seedVal    (seedVal),
    .scratchVal (scratchVal)
  );
endmodule

// File: rtl/crc_unit_checker.sv
module crc_unit_checker
  import crc_unit_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 clkEn,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wrData,
  input logic [DATA_W-1:0]    rdData,
  input logic [DATA_W-1:0]    crcVal,
  input logic [DATA_W-1:0]    seedVal,
  input logic [SCRATCH_W-1:0] scratchVal
);
  logic wrAct;
  assign wrAct = clkEn && wrEn;

  assert_disabled_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> rdData == '0);

  assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(crcVal) && $stable(seedVal) && $stable(scratchVal));

  assert_restart_seed_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrAct && addr == OFF_CTRL && wrData[0] |=> crcVal == $past(seedVal));

  assert_ctrl_reads_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    clkEn && addr == OFF_CTRL |-> rdData == '0);

  assert_self_residue_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrAct && addr == OFF_DATA && wrData == crcVal |=> crcVal == '0);

  assert_seed_write_keeps_crc_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrAct && addr == OFF_SEED |=> $stable(crcVal));

  assert_scratch_isolated_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrAct && addr == OFF_SCRATCH |=> $stable(crcVal) && $stable(seedVal));

  assert_gap_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrAct && (addr == 3'd3 || addr > OFF_SEED)
      |=> $stable(crcVal) && $stable(seedVal) && $stable(scratchVal));
endmodule

bind crc_word_unit crc_unit_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clkEn      (clkEn),
  .wrEn       (wrEn),
  .addr       (addr),
  .wrData     (wrData),
  .rdData     (rdData),
  .crcVal     (crcVal),
  .seedVal    (seedVal),
  .scratchVal (scratchVal)
);

// File: tb/crc_word_unit_bench.sv
module crc_word_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wrData = 32'd0;
  logic [31:0] rdData;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic [31:0] model;
  logic [31:0] modelSeed;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_word_unit u_crc_word_unit (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [31:0] refStep(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ 32'h04C11DB7;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdCheck("R1 data", 3'd0, 32'hFFFFFFFF);
    rdCheck("R1 seed", 3'd4, 32'hFFFFFFFF);
    rdCheck("R1 scratch", 3'd1, 32'h0);
    rdCheck("R1 ctrl", 3'd2, 32'h0);

    // R3 little-endian bytes 0a 00 00 00 form word 0x0000000A
    w = {8'h00, 8'h00, 8'h00, 8'h0a};
    wr(3'd0, w);
    rdCheck("R3", 3'd0, 32'hE88E0BAD);

    // R5 restart with default seed
    wr(3'd2, 32'h1);
    rdCheck("R5", 3'd0, 32'hFFFFFFFF);

    // R4 all-ones from reset gives zero
    wr(3'd0, 32'hFFFFFFFF);
    rdCheck("R4 ones", 3'd0, 32'h0);

    // R2 random streams, each closed by its own remainder (R4)
    for (int s = 0; s < 6; s++) begin
      wr(3'd2, 32'h1);
      model = 32'hFFFFFFFF;
      for (int n = 0; n < 20; n++) begin
        w = $urandom;
        wr(3'd0, w);
        model = refStep(model, w);
        rdCheck("R2", 3'd0, model);
      end
      wr(3'd0, model);
      rdCheck("R4 residue", 3'd0, 32'h0);
      model = 32'h0;
    end

    // R6 ctrl with bit0 clear leaves remainder; reads zero
    wr(3'd0, 32'h12345678);
    model = refStep(model, 32'h12345678);
    wr(3'd2, 32'hFFFFFFFE);
    rdCheck("R6 hold", 3'd0, model);
    rdCheck("R6 read", 3'd2, 32'h0);

    // R7 seed register R/W and restart load
    modelSeed = $urandom;
    wr(3'd4, modelSeed);
    rdCheck("R7 seed rd", 3'd4, modelSeed);
    rdCheck("R7 no effect", 3'd0, model);
    wr(3'd2, 32'h1);
    model = modelSeed;
    rdCheck("R7 restart", 3'd0, model);
    w = $urandom;
    wr(3'd0, w);
    model = refStep(model, w);
    rdCheck("R7 from seed", 3'd0, model);

    // R8 scratch
    wr(3'd1, 32'hCAFE_F00D);
    rdCheck("R8 width", 3'd1, 32'h0000000D);
    rdCheck("R8 no effect", 3'd0, model);
    wr(3'd2, 32'h1);
    model = modelSeed;
    rdCheck("R8 keep", 3'd1, 32'h0000000D);

    // R10 gap offsets
    for (int a = 3; a < 8; a++) begin
      if (a == 4) continue;
      wr(a[2:0], 32'hA5A5A5A5);
      rdCheck("R10 read", a[2:0], 32'h0);
    end
    rdCheck("R10 crc", 3'd0, model);
    rdCheck("R10 seed", 3'd4, modelSeed);
    rdCheck("R10 scratch", 3'd1, 32'h0000000D);

    // R9 disabled unit
    clkEn = 1'b0;
    wr(3'd0, 32'h55AA55AA);
    wr(3'd4, 32'h0);
    wr(3'd1, 32'h77);
    wr(3'd2, 32'h1);
    rdCheck("R9 read", 3'd0, 32'h0);
    rdCheck("R9 seed read", 3'd4, 32'h0);
    clkEn = 1'b1;
    rdCheck("R9 crc kept", 3'd0, model);
    rdCheck("R9 seed kept", 3'd4, modelSeed);
    rdCheck("R9 scratch kept", 3'd1, 32'h0000000D);

    finishRun();
  end
endmodule